// File: doc/BRIEF.md
# Add/Subtract Unit with Status Flags

This block adds or subtracts two operands of configurable width and reports the outcome through six status bits. The bits are unsigned carry/borrow, signed overflow, negative, zero, low-nibble carry/borrow and even parity of the low byte. The arithmetic result is combinational and follows the operands in the same cycle.

The status bits are captured in a register on a rising clock edge, but only in cycles where the load enable is high. When the enable is low, the last captured status stays in place. A datapath uses this so that the status reflects the most recent operation that was allowed to set it.

Top module: `addsub_flags_unit`

## Requirements
- R1: `result` equals `opd_a + opd_b` modulo 2^W when `sub_sel` is 0, and `opd_a - opd_b` modulo 2^W when `sub_sel` is 1. It changes in the same cycle as the operands.
- R2: `flags[0]` (carry) is the carry out of bit W-1 for an addition. For a subtraction it is the borrow, which is 1 exactly when `opd_a < opd_b` as unsigned numbers.
- R3: `flags[1]` (overflow) is set when the signed two's-complement outcome does not fit in W bits. For an addition, the operands have equal sign bits and the result sign differs from them. For a subtraction, the operand sign bits differ and the result sign differs from `opd_a`.
- R4: `flags[2]` (sign) equals bit W-1 of the result.
- R5: `flags[3]` (zero) is 1 exactly when every bit of the result is 0.
- R6: `flags[4]` (nibble carry) is the carry from bit 3 into bit 4 for an addition. For a subtraction it is the borrow, which is 1 when `opd_a[3:0] < opd_b[3:0]`.
- R7: `flags[5]` (parity) is 1 when `result[7:0]` contains an even number of 1 bits.
- R8: When `flag_we` is 1 at a rising clock edge, `flags` shows the status of that cycle's operation from that edge on.
- R9: When `flag_we` is 0 at a rising clock edge, `flags` keeps its value, while `result` still follows the operands.
- R10: An active-low asynchronous `rst_n` clears all six flag bits to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opd_a | input | W | First operand (minuend for subtraction) |
| opd_b | input | W | Second operand (subtrahend for subtraction) |
| sub_sel | input | 1 | 0 selects add, 1 selects subtract |
| flag_we | input | 1 | Loads the status register at the next edge |
| result | output | W | Combinational sum or difference |
| flags | output | 6 | Registered status: bits {parity, nibble carry, zero, sign, overflow, carry} from bit 5 to bit 0 |

## Verification
The result is due in the same cycle as its operands, so the bench drives at a falling edge and checks `result` one nanosecond later, before any clock edge. The flags are due one rising edge after a cycle with `flag_we` high. The bench therefore holds the operands through that edge and reads `flags` at the following falling edge. For the hold case, it drives new operands with the enable low, waits the same edge, and checks that `flags` is unchanged while `result` has moved.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    // Status word layout, bit 5 down to bit 0
    typedef struct packed {
        logic par;   // even parity of low byte
        logic aux;   // nibble carry / borrow
        logic zro;   // result is zero
        logic sgn;   // result msb
        logic ovf;   // signed overflow
        logic cry;   // carry / borrow
    } flag_t;

    localparam int FLAG_W = $bits(flag_t);

endpackage

// File: rtl/addsub_core.sv
module addsub_core #(
    parameter int W = 32
) (
    input  logic [W-1:0] opd_a,
    input  logic [W-1:0] opd_b,
    input  logic         sub_sel,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         nib_carry,
    output logic         b_msb_eff
);
    localparam int NIB = 4;

    logic [W-1:0] b_eff;
    logic [W:0]   wide;
    logic [NIB:0] nib;

    always_comb begin
        b_eff     = opd_b ^ {W{sub_sel}};
        wide      = {1'b0, opd_a} + {1'b0, b_eff} + {{W{1'b0}}, sub_sel};
        nib       = {1'b0, opd_a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, sub_sel};
        sum       = wide[W-1:0];
        // a borrow is the inverted carry of the two's-complement sum
        carry     = wide[W] ^ sub_sel;
        nib_carry = nib[NIB] ^ sub_sel;
        b_msb_eff = b_eff[W-1];
    end

endmodule

// File: rtl/flag_gen.sv
module flag_gen
    import addsub_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] sum,
    input  logic         a_msb,
    input  logic         b_msb_eff,
    input  logic         carry,
    input  logic         nib_carry,
    output flag_t        flg
);
    localparam int PW = (W < 8) ? W : 8;

    logic [PW-1:0] par_chain;

    genvar gi;
    generate
        for (gi = 0; gi < PW; gi++) begin : g_par
            if (gi == 0) begin : g_first
                assign par_chain[gi] = sum[gi];
            end else begin : g_next
                assign par_chain[gi] = par_chain[gi-1] ^ sum[gi];
            end
        end
    endgenerate

    always_comb begin
        flg.cry = carry;
        flg.ovf = (a_msb == b_msb_eff) && (sum[W-1] != a_msb);
        flg.sgn = sum[W-1];
        flg.zro = (sum == '0);
        flg.aux = nib_carry;
        flg.par = ~par_chain[PW-1];
    end

endmodule

// File: rtl/addsub_flags_unit.sv
module addsub_flags_unit
    import addsub_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] opd_a,
    input  logic [W-1:0] opd_b,
    input  logic         sub_sel,
    input  logic         flag_we,
    output logic [W-1:0] result,
    output logic [5:0]   flags
);
    typedef struct packed {
        flag_t flg;
    } state_t;

    state_t state_d, state_q;

    logic  carry, nib_carry, b_msb_eff;
    flag_t flg_now;

    addsub_core #(.W(W)) u_core (
        .opd_a     (opd_a),
        .opd_b     (opd_b),
        .sub_sel   (sub_sel),
        .sum       (result),
        .carry     (carry),
        .nib_carry (nib_carry),
        .b_msb_eff (b_msb_eff)
    );

    flag_gen #(.W(W)) u_flags (
        .sum       (result),
        .a_msb     (opd_a[W-1]),
        .b_msb_eff (b_msb_eff),
        .carry     (carry),
        .nib_carry (nib_carry),
        .flg       (flg_now)
    );

    always_comb begin
        state_d = state_q;
        if (flag_we) begin
            state_d.flg = flg_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flags = state_q.flg;

endmodule

// File: rtl/addsub_flags_chk.sv
module addsub_flags_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] opd_a,
    input logic [W-1:0] opd_b,
    input logic         sub_sel,
    input logic         flag_we,
    input logic [W-1:0] result,
    input logic [5:0]   flags
);
    // R10
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> flags == 6'b0);

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(flags));

    // R5
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> flags[3] == ($past(result) == '0));

    // R4
    sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> flags[2] == $past(result[W-1]));

    // R7
    parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> flags[5] == ~^$past(result[7:0]));

    // R2
    add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && !sub_sel) |=> flags[0] == ($past(result) < $past(opd_a)));

    // R2
    sub_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && sub_sel) |=> flags[0] == ($past(opd_a) < $past(opd_b)));

    // R8
    zero_not_negative_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags[3] |-> !flags[2]);

endmodule

bind addsub_flags_unit addsub_flags_chk #(.W(W)) u_addsub_flags_chk (.*);

// File: tb/test_addsub_flags_unit.sv
`timescale 1ns/1ps
module test_addsub_flags_unit;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] opd_a = '0;
    logic [TW-1:0] opd_b = '0;
    logic          sub_sel = 1'b0;
    logic          flag_we = 1'b0;
    logic [TW-1:0] result;
    logic [5:0]    flags;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    addsub_flags_unit #(.W(TW)) i_addsub_flags_unit (
        .clk     (clk),
        .rst_n   (rst_n),
        .opd_a   (opd_a),
        .opd_b   (opd_b),
        .sub_sel (sub_sel),
        .flag_we (flag_we),
        .result  (result),
        .flags   (flags)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h (a=%0h b=%0h sub=%0b)",
                     tag, got, exp, opd_a, opd_b, sub_sel);
        end
    endtask

    function automatic int ref_res(input int a, input int b, input bit s);
        return s ? ((a - b) & 255) : ((a + b) & 255);
    endfunction

    // returns {par, aux, zro, sgn, ovf, cry}
    function automatic logic [5:0] ref_flags(input int a, input int b, input bit s);
        int sa, sb, sr, r;
        logic [7:0] rb;
        logic c, ac, ov;
        sa = (a >= 128) ? a - 256 : a;
        sb = (b >= 128) ? b - 256 : b;
        if (!s) begin
            c  = (a + b) > 255;
            ac = ((a & 15) + (b & 15)) > 15;
            sr = sa + sb;
        end else begin
            c  = a < b;
            ac = (a & 15) < (b & 15);
            sr = sa - sb;
        end
        ov = (sr > 127) || (sr < -128);
        r  = ref_res(a, b, s);
        rb = r[7:0];
        return {($countones(rb) % 2) == 0, ac, rb == 8'h00, rb[7], ov, c};
    endfunction

    task automatic check_flags(input logic [5:0] e);
        chk("R2 carry",    int'(flags[0]), int'(e[0]));
        chk("R3 overflow", int'(flags[1]), int'(e[1]));
        chk("R4 sign",     int'(flags[2]), int'(e[2]));
        chk("R5 zero",     int'(flags[3]), int'(e[3]));
        chk("R6 nibble",   int'(flags[4]), int'(e[4]));
        chk("R7 parity",   int'(flags[5]), int'(e[5]));
    endtask

    // drive one operation with load enabled; result now, flags one edge later (R8)
    task automatic run_vec(input int a, input int b, input bit s);
        @(negedge clk);
        opd_a = a[7:0]; opd_b = b[7:0]; sub_sel = s; flag_we = 1'b1;
        #1;
        chk("R1 result", int'(result), ref_res(a, b, s));
        @(negedge clk);
        check_flags(ref_flags(a, b, s));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset flags", int'(flags), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 flags after release", int'(flags), 0);

        // corner cases
        run_vec(255, 1, 1'b0);
        run_vec(127, 1, 1'b0);
        run_vec(128, 128, 1'b0);
        run_vec(0, 1, 1'b1);
        run_vec(128, 1, 1'b1);
        run_vec(127, 255, 1'b1);
        run_vec(16, 1, 1'b1);
        run_vec(15, 1, 1'b0);
        run_vec(0, 0, 1'b1);

        // near-exhaustive sweep, both operations
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b += 5)
                    run_vec(a, b, s[0]);

        // R9: disabled load keeps flags, result still follows
        run_vec(255, 1, 1'b0);
        begin
            logic [5:0] held;
            held = ref_flags(255, 1, 1'b0);
            @(negedge clk);
            opd_a = 8'h03; opd_b = 8'h05; sub_sel = 1'b1; flag_we = 1'b0;
            #1;
            chk("R9 result moves", int'(result), ref_res(3, 5, 1'b1));
            @(negedge clk);
            chk("R9 flags held", int'(flags), int'(held));
            @(negedge clk);
            chk("R9 flags still held", int'(flags), int'(held));
        end

        // R10: asynchronous clear mid-run
        run_vec(3, 5, 1'b1);
        #0.5 rst_n = 1'b0;
        #0.5;
        chk("R10 async clear", int'(flags), 0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule